// File: doc/BRIEF.md
# Read-After-Write Address Hazard Detector

This block sits beside a write queue that feeds a slow serial target. Reads are not queued: a read holds the requesting bus until it completes. It is normally allowed to overtake the writes still waiting in the queue. That overtaking is unsafe when a queued write targets the same address. The detector compares the pending read address against every occupied queue slot in parallel. It reports whether the read must wait, and which slot it is waiting on.

The queue storage stays outside the block. The block receives the slot addresses and slot valid bits as flat vectors, together with the push and pop events. From those events it tracks the queue's head and tail itself, so it can rank matching slots by age. When several slots match, it pins the youngest of them. The conflict then persists until that slot pops, even if later writes to the same address arrive. A separate busy input blocks the read while a serial write is already under way.

Top module: `raw_hazard_detector`

## Requirements
- R1: Addresses are 7 bits wide. While `rd_valid` is 1, a read address equal to the address of a slot whose valid bit is 1 drives `conflict` to 1 in the same cycle, and `match_idx` gives that slot's index.
- R2: A slot whose valid bit is 0 never causes a conflict, whatever address it carries.
- R3: With `rd_valid` 1, no matching slot, no pinned slot and `xfer_busy` 0, both `conflict` and `rd_hold` are 0, so the read bypasses the queued writes.
- R4: When several slots match, `match_idx` is the youngest of them. Age is counted from the head slot, which starts at 0 after reset and advances by one, modulo the depth, on each `pop`. Tail also starts at 0 and advances on each `push`.
- R5: A write pushed in the same cycle as the read check takes part in the compare, at index tail, with address `push_addr`.
- R6: The head slot being popped in the current cycle takes no part in the compare.
- R7: Once a conflict is seen, the reported index is held. `conflict` stays 1 with the same `match_idx` while `rd_valid` stays 1, even when younger matching writes are pushed. This lasts until a `pop` occurs with the head equal to that index. `conflict` is still 1 in the pop cycle, and the hold is released from the next cycle.
- R8: `rd_hold` = `rd_valid` AND (`conflict` OR `xfer_busy`). A read is blocked while a serial write is in progress even without an address match.
- R9: With `rd_valid` 0, `conflict` and `rd_hold` are 0, and any held index is dropped.
- R10: During and right after reset, no conflict is held, and head and tail are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | A read is pending |
| rd_addr | input | ADDR_W (7) | Target address of the pending read |
| xfer_busy | input | 1 | A serial write transfer is in progress |
| push | input | 1 | A write enters the queue this cycle |
| push_addr | input | ADDR_W | Address of the entering write |
| pop | input | 1 | The head write leaves the queue this cycle |
| slot_addr | input | DEPTH*ADDR_W | Addresses of all queue slots, slot i at bits i*ADDR_W upward |
| slot_valid | input | DEPTH | Occupancy bit per slot |
| conflict | output | 1 | Read address collides with a queued write |
| match_idx | output | log2(DEPTH) | Slot the read is waiting on; meaningful when `conflict` is 1 |
| rd_hold | output | 1 | Read must not proceed this cycle |

## Verification
A wrong head or tail count shows up as a wrong `match_idx` on the first read that matches more than one slot. When the matching slots straddle the wrap point of the ring, the error appears in that same cycle. A held index that is lost or corrupted shows one cycle later. `conflict` then drops, or `match_idx` jumps to a newer slot, after an unrelated pop or a fresh push of the same address. A held index that fails to release keeps `rd_hold` high in the cycle after the matching pop. The bench therefore samples every cycle, against a ring model of its own.

// File: rtl/rhd_pkg.sv
package rhd_pkg;

  localparam int unsigned RHD_ADDR_W_DFLT = 7;

  // Distance of a slot from the head of the ring; 0 = oldest.
  function automatic int slot_age(int idx, int head, int depth);
    return ((idx - head) % depth + depth) % depth;
  endfunction

endpackage

// File: rtl/rhd_ptr_track.sv
module rhd_ptr_track #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] head_q,
  output logic [IDX_W-1:0] tail_q
);

  logic [IDX_W:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push) tail_q <= tail_q + 1'b1;
      if (pop)  head_q <= head_q + 1'b1;
      if (push && !pop)      count_q <= count_q + 1'b1;
      else if (pop && !push) count_q <= count_q - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (count_q < (IDX_W+1)'(DEPTH))); // R4

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count_q != '0)); // R4

  AST_RESET_PTRS: assert property (@(posedge clk)
    !rst_n |=> (head_q == '0 && tail_q == '0)); // R10

endmodule

// File: rtl/rhd_compare.sv
module rhd_compare
  import rhd_pkg::*;
#(
  parameter int unsigned ADDR_W = RHD_ADDR_W_DFLT,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic                    push,
  input  logic [ADDR_W-1:0]       push_addr,
  input  logic                    pop,
  input  logic [DEPTH*ADDR_W-1:0] slot_addr,
  input  logic [DEPTH-1:0]        slot_valid,
  input  logic [IDX_W-1:0]        head_q,
  input  logic [IDX_W-1:0]        tail_q,
  output logic                    any_match,
  output logic [IDX_W-1:0]        young_idx
);

  logic [DEPTH-1:0] eff_vld;
  logic [DEPTH-1:0] hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              is_tail;
    logic              is_head;
    logic [ADDR_W-1:0] eff_addr;
    assign is_tail  = push && (tail_q == IDX_W'(g));
    assign is_head  = pop  && (head_q == IDX_W'(g));
    assign eff_addr = is_tail ? push_addr : slot_addr[g*ADDR_W +: ADDR_W];
    assign eff_vld[g] = (slot_valid[g] && !is_head) || is_tail;
    assign hit[g]   = eff_vld[g] && (eff_addr == rd_addr);
  end

  always_comb begin
    int best_age;
    best_age  = -1;
    young_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit[i] && slot_age(i, int'(head_q), DEPTH) > best_age) begin
        best_age  = slot_age(i, int'(head_q), DEPTH);
        young_idx = IDX_W'(i);
      end
    end
  end

  assign any_match = |hit;

  AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_vld == '0) |-> !any_match); // R2

  AST_YOUNG_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    any_match |-> hit[young_idx]); // R4

endmodule

// File: rtl/rhd_pin.sv
module rhd_pin #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_valid,
  input  logic             any_match,
  input  logic [IDX_W-1:0] young_idx,
  input  logic             pop,
  input  logic [IDX_W-1:0] head_q,
  output logic             pin_vld,
  output logic [IDX_W-1:0] pin_idx
);

  logic pin_release;
  assign pin_release = pin_vld && pop && (head_q == pin_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_vld <= 1'b0;
      pin_idx <= '0;
    end else if (!rd_valid) begin
      pin_vld <= 1'b0;
    end else if (pin_vld) begin
      if (pin_release) pin_vld <= 1'b0;
    end else if (any_match) begin
      pin_vld <= 1'b1;
      pin_idx <= young_idx;
    end
  end

  AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_vld && rd_valid && !pin_release) |=> (pin_vld && $stable(pin_idx))); // R7

  AST_PIN_FREED: assert property (@(posedge clk) disable iff (!rst_n)
    pin_release |=> !pin_vld); // R7

  AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !pin_vld); // R9

endmodule

// File: rtl/raw_hazard_detector.sv
module raw_hazard_detector
  import rhd_pkg::*;
#(
  parameter int unsigned ADDR_W = RHD_ADDR_W_DFLT,
  parameter int unsigned DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_valid,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic                       xfer_busy,
  input  logic                       push,
  input  logic [ADDR_W-1:0]          push_addr,
  input  logic                       pop,
  input  logic [DEPTH*ADDR_W-1:0]    slot_addr,
  input  logic [DEPTH-1:0]           slot_valid,
  output logic                       conflict,
  output logic [$clog2(DEPTH)-1:0]   match_idx,
  output logic                       rd_hold
);

  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0] head_q;
  logic [IDX_W-1:0] tail_q;
  logic             any_match;
  logic [IDX_W-1:0] young_idx;
  logic             pin_vld;
  logic [IDX_W-1:0] pin_idx;

  rhd_ptr_track #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .head_q(head_q), .tail_q(tail_q)
  );

  rhd_compare #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_cmp (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .push(push),
    .push_addr(push_addr), .pop(pop), .slot_addr(slot_addr),
    .slot_valid(slot_valid), .head_q(head_q), .tail_q(tail_q),
    .any_match(any_match), .young_idx(young_idx)
  );

  rhd_pin #(.DEPTH(DEPTH)) u_pin (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .any_match(any_match),
    .young_idx(young_idx), .pop(pop), .head_q(head_q),
    .pin_vld(pin_vld), .pin_idx(pin_idx)
  );

  assign conflict  = rd_valid && (pin_vld || any_match);
  assign match_idx = pin_vld ? pin_idx : young_idx;
  assign rd_hold   = rd_valid && (conflict || xfer_busy);

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && xfer_busy) |-> rd_hold); // R8

  AST_BYPASS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !xfer_busy && !any_match && !pin_vld) |-> !rd_hold); // R3

  AST_HIT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && any_match) |-> conflict); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (!conflict && !rd_hold)); // R9

endmodule

// File: tb/tb_raw_hazard_detector.sv
`timescale 1ns/1ps
module tb_raw_hazard_detector;

  localparam int AW = 7;
  localparam int DP = 8;
  localparam int IW = $clog2(DP);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rd_valid = 1'b0;
  logic [AW-1:0]     rd_addr = '0;
  logic              xfer_busy = 1'b0;
  logic              push = 1'b0;
  logic [AW-1:0]     push_addr = '0;
  logic              pop = 1'b0;
  logic [DP*AW-1:0]  slot_addr = '0;
  logic [DP-1:0]     slot_valid = '0;
  logic              conflict;
  logic [IW-1:0]     match_idx;
  logic              rd_hold;

  raw_hazard_detector #(.ADDR_W(AW), .DEPTH(DP)) dut (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .xfer_busy(xfer_busy), .push(push), .push_addr(push_addr), .pop(pop),
    .slot_addr(slot_addr), .slot_valid(slot_valid),
    .conflict(conflict), .match_idx(match_idx), .rd_hold(rd_hold)
  );

  always #4 clk = ~clk;

  // reference ring
  int        m_addr [DP];
  bit        m_vld  [DP];
  int        m_head = 0, m_tail = 0, m_cnt = 0;
  bit        m_pin = 0;
  int        m_pin_idx = 0;

  // scoreboard
  bit        q_conf[$];
  int        q_idx[$];
  bit        q_hold[$];
  string     q_tag[$];
  int        n_vec = 0, n_bad = 0;
  bit        finished = 0;

  always @(negedge clk) begin
    #2;
    if (q_conf.size() > 0) begin
      bit e_c, e_h; int e_i; string t;
      e_c = q_conf.pop_front(); e_i = q_idx.pop_front();
      e_h = q_hold.pop_front(); t = q_tag.pop_front();
      n_vec++;
      if (conflict !== e_c || rd_hold !== e_h || (e_c && int'(match_idx) != e_i)) begin
        n_bad++;
        $display("FAIL %s: conflict=%0b idx=%0d hold=%0b expected conflict=%0b idx=%0d hold=%0b",
                 t, conflict, match_idx, rd_hold, e_c, e_i, e_h);
      end
    end
  end

  task automatic cyc(bit rv, int ra, bit ps, int pa, bit pp, bit bz, string tag);
    bit hit_any; int young; bit e_c; int ei_addr; bit ei_vld; int s;
    @(negedge clk);
    rd_valid = rv; rd_addr = AW'(ra); push = ps; push_addr = AW'(pa);
    pop = pp; xfer_busy = bz;
    for (int i = 0; i < DP; i++) begin
      slot_addr[i*AW +: AW] = AW'(m_addr[i]);
      slot_valid[i] = m_vld[i];
    end
    hit_any = 0; young = 0;
    for (int k = DP-1; k >= 0; k--) begin
      s = (m_head + k) % DP;
      ei_addr = (ps && s == m_tail) ? pa : m_addr[s];
      ei_vld  = (m_vld[s] && !(pp && s == m_head)) || (ps && s == m_tail);
      if (!hit_any && ei_vld && ei_addr == ra) begin hit_any = 1; young = s; end
    end
    e_c = rst_n && rv && (m_pin || hit_any);
    q_conf.push_back(e_c);
    q_idx.push_back(m_pin ? m_pin_idx : young);
    q_hold.push_back(rst_n && rv && (e_c || bz));
    q_tag.push_back(tag);
    @(posedge clk);
    if (!rst_n) begin
      m_pin = 0; m_head = 0; m_tail = 0; m_cnt = 0;
    end else begin
      if (!rv) m_pin = 0;
      else if (m_pin) begin
        if (pp && m_head == m_pin_idx) m_pin = 0;
      end else if (hit_any) begin m_pin = 1; m_pin_idx = young; end
      if (pp) begin m_vld[m_head] = 0; m_head = (m_head + 1) % DP; m_cnt--; end
      if (ps) begin m_addr[m_tail] = pa; m_vld[m_tail] = 1; m_tail = (m_tail + 1) % DP; m_cnt++; end
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int lf;
    for (int i = 0; i < DP; i++) begin m_addr[i] = 0; m_vld[i] = 0; end
    // R10: reset state, read pending but nothing may be flagged
    cyc(1, 0, 0, 0, 0, 0, "R10 in reset");
    cyc(0, 0, 0, 0, 0, 0, "R10 in reset");
    @(negedge clk); rst_n = 1;
    // R5 + R10: same-cycle push at index 0 matches
    cyc(1, 'h15, 1, 'h15, 0, 0, "R5 same-cycle push idx0");
    cyc(1, 'h15, 0, 0, 0, 0, "R7 held");
    cyc(0, 'h15, 1, 'h22, 0, 0, "R9 idle no conflict");
    cyc(0, 'h15, 1, 'h15, 0, 0, "R9 idle no conflict");
    cyc(0, 'h15, 1, 'h30, 0, 0, "R9 idle no conflict");
    // R4: slots 0,2 match -> youngest 2
    cyc(1, 'h15, 0, 0, 0, 0, "R4 youngest of two");
    cyc(1, 'h15, 1, 'h15, 0, 0, "R7 newer push ignored");
    cyc(1, 'h15, 0, 0, 1, 0, "R7 held across pop");
    cyc(1, 'h15, 0, 0, 1, 0, "R7 held across pop");
    cyc(1, 'h15, 0, 0, 1, 0, "R7 pop cycle still held");
    cyc(1, 'h15, 0, 0, 0, 0, "R7 released then re-judged");
    cyc(0, 'h15, 0, 0, 0, 0, "R9 drop");
    // R3 / R8
    cyc(1, 'h7F, 0, 0, 0, 0, "R3 bypass");
    cyc(1, 'h7F, 0, 0, 0, 1, "R8 busy blocks");
    // R2: stale address 0x22 in empty slot 1
    cyc(1, 'h22, 0, 0, 0, 0, "R2 invalid slot");
    cyc(0, 0, 0, 0, 0, 0, "R9 idle");
    // R6: head slot 3 holds 0x30, popped this cycle
    cyc(1, 'h30, 0, 0, 1, 0, "R6 popped head excluded");
    cyc(1, 'h30, 0, 0, 0, 0, "R6 after pop");
    cyc(0, 0, 0, 0, 1, 0, "R9 idle");
    // wrap: head now 5, fill across the ring end
    cyc(0, 0, 1, 'h11, 0, 0, "R9 idle");
    cyc(0, 0, 1, 'h02, 0, 0, "R9 idle");
    cyc(0, 0, 1, 'h11, 0, 0, "R9 idle");
    cyc(0, 0, 1, 'h11, 0, 0, "R9 idle");
    cyc(1, 'h11, 0, 0, 0, 0, "R4 youngest across wrap");
    cyc(1, 'h11, 0, 0, 0, 1, "R8 busy and conflict");
    cyc(0, 0, 0, 0, 0, 0, "R9 idle");
    cyc(1, 'h02, 0, 0, 0, 0, "R1 single match");
    cyc(0, 0, 0, 0, 0, 0, "R9 idle");
    // pseudo-random traffic
    lf = 32'h1ACE;
    for (int n = 0; n < 600; n++) begin
      bit ps, pp;
      lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
      ps = lf[3] && (m_cnt < DP - 1);
      pp = lf[5] && (m_cnt > 0);
      cyc(lf[0] | lf[1], 5 + (lf[7:6] % 3), ps, 5 + (lf[9:8] % 3), pp, lf[10] & lf[11], "R1 random traffic");
    end
    @(negedge clk); @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule